// File: doc/BRIEF.md
# Multiword Arithmetic Halving Unit

This block divides a signed integer of up to four 16-bit words by two, one word per command. The words sit in a small internal register file. Each halving command names one word and a fill mode. The word is shifted right by one place and written back to the same word. The new top bit comes from one of four places: the word's own sign bit, bit 0 of the next higher word in the file, bit 0 of an external word given with the command, or bit 0 of the word that the previous halving command read before shifting it. With these modes a 64-bit value can be halved in either word order, and the words may also be fed in from outside.

Commands enter on one 3-bit port with an address and a data word. Each command is latched at one rising edge and carried out at the next. The exception is clear, which acts at the edge that latches it. Load commands fill the file. A registered read port returns any word. The result of the last halving command, the bit shifted out of it, and a one-cycle valid pulse are held on registered outputs.

Top module: `mwh_halver`

## Requirements
- R1: A command on `cmd` is latched at one rising edge and carried out at the following edge, so `res_vld` rises after the second edge following a halving command.
- R2: Command code 2 (sign mode) writes {w[15], w[15:1]} for operand word w, which keeps the sign.
- R3: Command code 3 (next mode) fills bit 15 from bit 0 of file word addr+1, and the top address wraps to word 0.
- R4: Command code 4 (external mode) fills bit 15 from bit 0 of `cmd_data` given with the command.
- R5: Command code 5 (previous mode) fills bit 15 from bit 0 of the unshifted operand of the most recent halving command. That value is kept through idle cycles and is zero after clear or reset.
- R6: A halving command writes the shifted word back to file word `cmd_addr` and to `res_word`, puts the old bit 0 on `carry_out`, and pulses `res_vld` high for one cycle.
- R7: `res_word` and `carry_out` hold their values in every cycle in which no halving command completes.
- R8: Command code 1 (load) writes `cmd_data` into file word `cmd_addr` at the execute edge.
- R9: Command code 6 (clear), at the edge that latches it, zeroes every file word, `res_word`, `carry_out` and `res_vld`, and drops the command latched one edge earlier.
- R10: Synchronous active-high `rst` puts the block into the same zero state as clear.
- R11: `rd_data` is registered and returns file word `rd_addr` as it stood before any write made at the same edge.
- R12: Command codes 0 and 7 change no file word and no output.
- R13: Halving all four words, with sign mode on word 3 and any of the fill modes on the lower words applied in a valid order, leaves floor(v/2) of the signed 64-bit value v in the file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Command code: 0 idle, 1 load, 2 sign, 3 next, 4 external, 5 previous, 6 clear, 7 idle |
| cmd_addr | input | 2 | File word addressed by the command |
| cmd_data | input | 16 | Load data, or neighbour word for external mode |
| rd_addr | input | 2 | Read port address |
| rd_data | output | 16 | Registered read data |
| res_word | output | 16 | Result of the last halving command |
| carry_out | output | 1 | Bit shifted out of the last halving command |
| res_vld | output | 1 | One-cycle pulse when a halving command completes |

## Verification
The hardest cases to reach from the ports are the ordering hazards: a fill bit must be the neighbour's original bit 0, not a bit that was already shifted, and a clear arriving one cycle behind a halving command must drop that command. The stimulus halves whole 64-bit values in three orders. Upward chains use next mode, downward chains use previous mode, and mixed orders use external mode. The commands are issued back to back, so each fill is read in the very cycle after its neighbour was written. A separate sequence places a clear directly behind a halving command. Another reads a word at the exact edge a load overwrites it.

// File: rtl/mwh_pkg.sv
package mwh_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_LOAD = 3'd1,
    CMD_SGN  = 3'd2,
    CMD_NXT  = 3'd3,
    CMD_EXT  = 3'd4,
    CMD_PRV  = 3'd5,
    CMD_CLR  = 3'd6,
    CMD_RSV  = 3'd7
  } mwh_cmd_e;

  function automatic logic is_halve(input mwh_cmd_e c);
    return (c == CMD_SGN) || (c == CMD_NXT) || (c == CMD_EXT) || (c == CMD_PRV);
  endfunction

endpackage

// File: rtl/mwh_cmd_latch.sv
module mwh_cmd_latch
  import mwh_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [2:0]    cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  data_i,
  output mwh_cmd_e      x_cmd,
  output logic [AW-1:0] x_addr,
  output logic [W-1:0]  x_data
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      x_cmd  <= CMD_NOP;
      x_addr <= '0;
      x_data <= '0;
    end else begin
      x_cmd  <= mwh_cmd_e'(cmd_i);
      x_addr <= addr_i;
      x_data <= data_i;
    end
  end

endmodule

// File: rtl/mwh_regfile.sv
module mwh_regfile #(
  parameter int W  = 16,
  parameter int N  = 4,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_op,
  input  logic [AW-1:0] ra_nbr,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  op_word,
  output logic [W-1:0]  nbr_word,
  output logic [W-1:0]  rd_q
);

  logic [W-1:0] mem [N];

  for (genvar i = 0; i < N; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        mem[i] <= '0;
      end else if (we && (waddr == AW'(i))) begin
        mem[i] <= wdata;
      end
    end
  end

  assign op_word  = mem[ra_op];
  assign nbr_word = mem[ra_nbr];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rd_q <= '0;
    end else begin
      rd_q <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/mwh_fill_sel.sv
module mwh_fill_sel
  import mwh_pkg::*;
#(
  parameter int W = 16
) (
  input  mwh_cmd_e     mode,
  input  logic [W-1:0] op_word,
  input  logic [W-1:0] nbr_word,
  input  logic [W-1:0] ext_word,
  input  logic [W-1:0] prev_word,
  output logic         fill
);

  always_comb begin
    unique case (mode)
      CMD_SGN: fill = op_word[W-1];
      CMD_NXT: fill = nbr_word[0];
      CMD_EXT: fill = ext_word[0];
      CMD_PRV: fill = prev_word[0];
      default: fill = 1'b0;
    endcase
  end

endmodule

// File: rtl/mwh_halve_core.sv
module mwh_halve_core #(
  parameter int W = 16
) (
  input  logic [W-1:0] op_word,
  input  logic         fill,
  output logic [W-1:0] res,
  output logic         co
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == W - 1) begin : g_top
      assign res[b] = fill;
    end else begin : g_low
      assign res[b] = op_word[b+1];
    end
  end

  assign co = op_word[0];

endmodule

// File: rtl/mwh_halver.sv
module mwh_halver
  import mwh_pkg::*;
#(
  parameter int W  = 16,
  parameter int N  = 4,
  parameter int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cmd,
  input  logic [AW-1:0] cmd_addr,
  input  logic [W-1:0]  cmd_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  res_word,
  output logic          carry_out,
  output logic          res_vld
);

  localparam logic [AW-1:0] TOP_ADDR = AW'(N - 1);

  mwh_cmd_e      x_cmd;
  logic [AW-1:0] x_addr;
  logic [W-1:0]  x_data;
  logic          clr_now;
  logic          x_halve;
  logic [AW-1:0] nbr_addr;
  logic [W-1:0]  op_word;
  logic [W-1:0]  nbr_word;
  logic [W-1:0]  prev_q;
  logic          fill;
  logic [W-1:0]  res;
  logic          co;
  logic          rf_we;
  logic [W-1:0]  rf_wdata;

  assign clr_now  = (cmd == 3'(CMD_CLR));
  assign x_halve  = is_halve(x_cmd);
  assign nbr_addr = (x_addr == TOP_ADDR) ? '0 : x_addr + AW'(1);
  assign rf_we    = !clr_now && (x_halve || (x_cmd == CMD_LOAD));
  assign rf_wdata = x_halve ? res : x_data;

  mwh_cmd_latch #(.W(W), .AW(AW)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_now),
    .cmd_i  (cmd),
    .addr_i (cmd_addr),
    .data_i (cmd_data),
    .x_cmd  (x_cmd),
    .x_addr (x_addr),
    .x_data (x_data)
  );

  mwh_regfile #(.W(W), .N(N), .AW(AW)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_now),
    .we       (rf_we),
    .waddr    (x_addr),
    .wdata    (rf_wdata),
    .ra_op    (x_addr),
    .ra_nbr   (nbr_addr),
    .rd_addr  (rd_addr),
    .op_word  (op_word),
    .nbr_word (nbr_word),
    .rd_q     (rd_data)
  );

  mwh_fill_sel #(.W(W)) u_fill (
    .mode      (x_cmd),
    .op_word   (op_word),
    .nbr_word  (nbr_word),
    .ext_word  (x_data),
    .prev_word (prev_q),
    .fill      (fill)
  );

  mwh_halve_core #(.W(W)) u_core (
    .op_word (op_word),
    .fill    (fill),
    .res     (res),
    .co      (co)
  );

  always_ff @(posedge clk) begin
    if (rst || clr_now) begin
      res_word  <= '0;
      carry_out <= 1'b0;
      res_vld   <= 1'b0;
      prev_q    <= '0;
    end else begin
      res_vld <= x_halve;
      if (x_halve) begin
        res_word  <= res;
        carry_out <= co;
        prev_q    <= op_word;
      end
    end
  end

endmodule

// File: rtl/mwh_halver_chk.sv
module mwh_halver_chk
  import mwh_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    cmd,
  input logic [2:0]    x_cmd,
  input logic [W-1:0]  x_data,
  input logic [W-1:0]  op_word,
  input logic [W-1:0]  res_word,
  input logic          carry_out,
  input logic          res_vld
);

  // R1
  vld_source_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> ($past(x_cmd) == 3'(CMD_SGN) || $past(x_cmd) == 3'(CMD_NXT) ||
                 $past(x_cmd) == 3'(CMD_EXT) || $past(x_cmd) == 3'(CMD_PRV)));

  // R6
  shift_value_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> ({res_word[W-2:0], carry_out} == $past(op_word)));

  // R2
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (res_vld && $past(x_cmd) == 3'(CMD_SGN)) |-> (res_word[W-1] == res_word[W-2]));

  // R4
  ext_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (res_vld && $past(x_cmd) == 3'(CMD_EXT)) |-> (res_word[W-1] == $past(x_data[0])));

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!res_vld && !$past(rst) && $past(cmd) != 3'(CMD_CLR)) |->
      ($stable(res_word) && $stable(carry_out)));

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd) == 3'(CMD_CLR)) |-> (res_word == '0 && !carry_out && !res_vld));

endmodule

bind mwh_halver mwh_halver_chk #(.W(W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd       (cmd),
  .x_cmd     (x_cmd),
  .x_data    (x_data),
  .op_word   (op_word),
  .res_word  (res_word),
  .carry_out (carry_out),
  .res_vld   (res_vld)
);

// File: tb/mwh_halver_tb.sv
module mwh_halver_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] C_NOP = 3'd0, C_LOAD = 3'd1, C_SGN = 3'd2, C_NXT = 3'd3,
                         C_EXT = 3'd4, C_PRV = 3'd5, C_CLR = 3'd6, C_RSV = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  cmd_addr = 2'd0;
  logic [15:0] cmd_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic [15:0] res_word;
  logic        carry_out;
  logic        res_vld;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] res;
    logic        co;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mwh_halver u_dut (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .res_word  (res_word),
    .carry_out (carry_out),
    .res_vld   (res_vld)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed halving command (R6)
  always @(negedge clk) begin
    if (!rst && res_vld) begin
      if (sb_q.size() == 0) begin
        chk("R6/R12 unexpected res_vld", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.tag, " res_word"}, 64'(res_word), 64'(e.res));
        chk({e.tag, " carry_out"}, 64'(carry_out), 64'(e.co));
      end
    end
  end

  task automatic send(input logic [2:0] c, input int a, input logic [15:0] d);
    @(negedge clk);
    cmd = c;
    cmd_addr = 2'(a);
    cmd_data = d;
  endtask

  task automatic send_h(input logic [2:0] c, input int a, input logic [15:0] d,
                        input logic [15:0] er, input logic eco, input string tag);
    exp_t e;
    e.res = er;
    e.co  = eco;
    e.tag = tag;
    sb_q.push_back(e);
    send(c, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd = C_NOP;
    end
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk);
    cmd = C_NOP;
    rd_addr = 2'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic load64(input logic [63:0] v);
    for (int i = 0; i < 4; i++) send(C_LOAD, i, v[16*i +: 16]);
    idle(2);
  endtask

  task automatic read64(output logic [63:0] v);
    logic [15:0] w;
    for (int i = 0; i < 4; i++) begin
      rd(i, w);
      v[16*i +: 16] = w;
    end
  endtask

  // R13: halve a 64-bit value; order 0 uses next mode upward, 1 previous mode downward, 2 external mode
  task automatic halve64(input logic [63:0] v, input int order);
    logic [63:0] h;
    logic [63:0] got;
    h = 64'($signed(v) >>> 1);
    load64(v);
    if (order == 0) begin
      for (int i = 0; i < 3; i++) send_h(C_NXT, i, 16'h0, h[16*i +: 16], v[16*i], "R3 next chain");
      send_h(C_SGN, 3, 16'h0, h[63:48], v[48], "R2 top sign");
    end else if (order == 1) begin
      send_h(C_SGN, 3, 16'h0, h[63:48], v[48], "R2 top sign");
      for (int i = 2; i >= 0; i--) send_h(C_PRV, i, 16'h0, h[16*i +: 16], v[16*i], "R5 prev chain");
    end else begin
      send_h(C_EXT, 1, v[47:32], h[31:16], v[16], "R4 ext fill");
      send_h(C_SGN, 3, 16'h0, h[63:48], v[48], "R2 top sign");
      send_h(C_EXT, 0, v[31:16], h[15:0], v[0], "R4 ext fill");
      send_h(C_EXT, 2, v[63:48], h[47:32], v[32], "R4 ext fill");
    end
    idle(3);
    read64(got);
    chk("R13 64-bit floor halve", got, h);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic [63:0] got;
    logic [63:0] vals [5];
    vals[0] = 64'h8000_0000_0000_0001;
    vals[1] = 64'h0001_0001_0001_0001;
    vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    vals[3] = 64'h7FFF_0000_FFFF_0002;
    vals[4] = 64'h1234_5678_9ABC_DEF1;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 reset res_word", 64'(res_word), 64'd0);
    chk("R10 reset carry_out", 64'(carry_out), 64'd0);
    chk("R10 reset res_vld", 64'(res_vld), 64'd0);
    read64(got);
    chk("R10 reset file", got, 64'd0);

    // R8 load then read back
    load64(64'hDEAD_BEEF_0123_4567);
    read64(got);
    chk("R8 load readback", got, 64'hDEAD_BEEF_0123_4567);

    // R1 latency: result valid after the second edge
    send_h(C_SGN, 3, 16'h0, 16'hEF56, 1'b1, "R1 latency op");
    @(negedge clk);
    cmd = C_NOP;
    chk("R1 not valid after first edge", 64'(res_vld), 64'd0);
    @(negedge clk);
    chk("R1 valid after second edge", 64'(res_vld), 64'd1);
    idle(1);
    chk("R6 res_vld one-cycle pulse", 64'(res_vld), 64'd0);
    // R7 hold while idle
    idle(4);
    chk("R7 hold res_word", 64'(res_word), 64'hEF56);
    chk("R7 hold carry_out", 64'(carry_out), 64'd1);

    // R13 chains in all three orders
    for (int k = 0; k < 5; k++) begin
      for (int o = 0; o < 3; o++) halve64(vals[k], o);
    end

    // R3 wrap: top word fills from word 0
    load64(64'h4000_0000_0000_0001);
    send_h(C_NXT, 3, 16'h0, 16'hA000, 1'b0, "R3 wrap");
    idle(3);
    rd(3, w);
    chk("R3 wrap writeback", 64'(w), 64'hA000);

    // R5 previous value kept over idle cycles
    load64(64'h0000_0000_0000_0003);
    send_h(C_SGN, 0, 16'h0, 16'h0001, 1'b1, "R5 seed");
    idle(6);
    send_h(C_PRV, 2, 16'h0, 16'h8000, 1'b0, "R5 kept over idle");
    idle(3);

    // R12 reserved and idle codes do nothing
    load64(64'h1111_2222_3333_4444);
    send(C_RSV, 1, 16'hFFFF);
    send(C_NOP, 2, 16'hFFFF);
    idle(3);
    read64(got);
    chk("R12 file unchanged", got, 64'h1111_2222_3333_4444);
    chk("R12 res_word unchanged", 64'(res_word), 64'h8000);

    // R11 read before write at the same edge
    @(negedge clk);
    cmd = C_LOAD; cmd_addr = 2'd2; cmd_data = 16'hAAAA; rd_addr = 2'd2;
    @(negedge clk);
    cmd = C_NOP;
    @(negedge clk);
    chk("R11 old value at write edge", 64'(rd_data), 64'h2222);
    @(negedge clk);
    chk("R11 new value after write", 64'(rd_data), 64'hAAAA);

    // R9 clear right behind a halving command drops it
    send_h(C_SGN, 0, 16'h0, 16'h2222, 1'b0, "R9 pre-clear op");
    idle(3);
    send(C_NXT, 1, 16'h0);
    send(C_CLR, 0, 16'h0);
    idle(1);
    chk("R9 clear res_word", 64'(res_word), 64'd0);
    chk("R9 clear res_vld", 64'(res_vld), 64'd0);
    idle(3);
    chk("R9 dropped op no result", 64'(res_vld), 64'd0);
    chk("R9 clear carry_out", 64'(carry_out), 64'd0);
    read64(got);
    chk("R9 clear file", got, 64'd0);
    // R5 previous value zero after clear
    send(C_LOAD, 1, 16'h8002);
    send_h(C_PRV, 1, 16'h0, 16'h4001, 1'b0, "R5 zero after clear");
    idle(3);

    // R10 reset mid-run
    load64(64'h5555_6666_7777_8888);
    send_h(C_NXT, 0, 16'h0, 16'hC444, 1'b0, "R10 pre-reset op");
    idle(3);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 reset res_word", 64'(res_word), 64'd0);
    chk("R10 reset carry_out", 64'(carry_out), 64'd0);
    read64(got);
    chk("R10 reset file mid-run", got, 64'd0);

    idle(3);
    chk("R6 all results seen", 64'(sb_q.size()), 64'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule